// File: doc/BRIEF.md
# ASCII Matrix Stream Parser

The parser consumes a byte stream of ASCII text, typically delivered by a serial receiver, that carries a matrix of non-negative decimal integers. Digits are folded into a binary accumulator as they arrive. A separator, a line break or the end-of-text marker closes the current number, and the value goes out on a memory write port in row-major order. Every closed number also counts toward the current row's width. Every non-empty line counts as a row.

Once the end-of-text byte arrives, the block pulses `done` and freezes. The `mat_rows` and `mat_cols` outputs then give the matrix size. A shape flag shows whether the rows had unequal widths, and an overflow flag shows whether a number had to be clipped.

A header mode is provided for senders that know the matrix size in advance. In this mode the first two numbers are taken as the row count and the column count, and only the numbers after them are written to memory.

Top module: `ascii_matrix_parser`

## Requirements
- R1: A digit byte (0x30 to 0x39) updates the accumulator to acc*10 + (byte - 0x30). A digit never causes a write. The closed number appears on `wr_data` with `wr_en` high exactly one cycle after the byte that closes it is accepted. A space (0x20) or a comma (0x2C) closes a number.
- R2: Written values go to addresses 0, 1, 2, ... in order of arrival, which is row-major order, with one write per number.
- R3: Several separators in a row, and blank lines, produce no write. A carriage return (0x0D) and any other byte that is not a digit, separator, newline or end-of-text are ignored. Such a byte does not close or change the pending number.
- R4: A newline (0x0A) or an end-of-text (0x04) that follows digits also closes the pending number and writes it.
- R5: In text mode, `mat_cols` takes the number count of the first non-empty row.
- R6: In text mode, `mat_rows` counts the non-empty lines. This includes a last line that ends with end-of-text instead of a newline.
- R7: In text mode, `shape_err` rises if any later row holds a different number of values than the first row, and it then stays high until reset.
- R8: `done` is high for exactly one cycle, in the cycle after the end-of-text byte is accepted. After that, all input is ignored until reset: no writes, no further `done`, and `mat_rows`/`mat_cols` stay fixed.
- R9: A number whose value exceeds 2^DATA_W-1 is clipped to 2^DATA_W-1, and `ovf` is set and stays set until reset. The value 2^DATA_W-1 itself does not set `ovf`.
- R10: With `header_mode` high, the first number goes to `mat_rows` and the second to `mat_cols`. Neither is written. The numbers that follow are written from address 0. In this mode a newline acts only as a separator.
- R11: While reset is held, and right after it is released, `wr_en`, `done`, `mat_rows`, `mat_cols`, `shape_err` and `ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| header_mode | input | 1 | 1: the first two numbers give the matrix size |
| in_byte | input | 8 | Incoming ASCII byte |
| in_valid | input | 1 | `in_byte` is valid in this cycle |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Converted value |
| done | output | 1 | One-cycle pulse after end-of-text |
| mat_rows | output | DIM_W | Row count |
| mat_cols | output | DIM_W | Column count |
| shape_err | output | 1 | Rows of unequal width were seen |
| ovf | output | 1 | A number was clipped |

## Verification
Every result is registered once. A closing byte accepted at one edge shows up as a write at that same edge, and so appears on the ports in the following cycle. Likewise, `done` and the row, column and flag updates are visible one cycle after the byte that causes them. The bench drives bytes on the falling edge and records the write port on every falling edge, so each write is captured one cycle after its closing byte. The `done` pulse is checked on the first falling edge after end-of-text and checked again to be low on the next. The counts and flags are read only after that, when nothing more can change them.

// File: rtl/ascii_matrix_parser.sv
module ascii_matrix_parser #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              header_mode,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic [DIM_W-1:0]  mat_rows,
  output logic [DIM_W-1:0]  mat_cols,
  output logic              shape_err,
  output logic              ovf
);
  localparam int WW = DATA_W + 4;

  logic [DATA_W-1:0] acc_q;
  logic              have_q;
  logic [DIM_W-1:0]  row_vals_q;
  logic              first_q;
  logic [DIM_W-1:0]  rows_q, cols_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        hdr_idx_q;
  logic              fin_q, done_q, shape_q, ovf_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic              act, is_digit, is_sep, is_nl, is_eof, flush, row_end, emit, sat;
  logic [WW-1:0]     wide;
  logic [DATA_W-1:0] acc_next;
  logic [DIM_W-1:0]  row_total;

  assign act       = in_valid && !fin_q;
  assign is_digit  = (in_byte >= 8'h30) && (in_byte <= 8'h39);
  assign is_sep    = (in_byte == 8'h20) || (in_byte == 8'h2C);
  assign is_nl     = (in_byte == 8'h0A);
  assign is_eof    = (in_byte == 8'h04);
  assign wide      = WW'(acc_q) * WW'(10) + WW'(in_byte[3:0]);
  assign sat       = |wide[WW-1:DATA_W];
  assign acc_next  = sat ? {DATA_W{1'b1}} : wide[DATA_W-1:0];
  assign flush     = act && have_q && (is_sep || is_nl || is_eof);
  assign row_end   = act && !header_mode && (is_nl || is_eof);
  assign emit      = flush && (!header_mode || hdr_idx_q == 2'd2);
  assign row_total = row_vals_q + (flush ? DIM_W'(1) : DIM_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      have_q     <= 1'b0;
      row_vals_q <= '0;
      first_q    <= 1'b0;
      rows_q     <= '0;
      cols_q     <= '0;
      addr_q     <= '0;
      hdr_idx_q  <= '0;
      fin_q      <= 1'b0;
      done_q     <= 1'b0;
      shape_q    <= 1'b0;
      ovf_q      <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      if (act && is_digit) begin
        acc_q  <= acc_next;
        have_q <= 1'b1;
        if (sat) ovf_q <= 1'b1;
      end
      if (flush) begin
        acc_q      <= '0;
        have_q     <= 1'b0;
        row_vals_q <= row_vals_q + DIM_W'(1);
        if (header_mode && hdr_idx_q != 2'd2) begin
          hdr_idx_q <= hdr_idx_q + 2'd1;
          if (hdr_idx_q == 2'd0) rows_q <= acc_q[DIM_W-1:0];
          else                   cols_q <= acc_q[DIM_W-1:0];
        end
      end
      if (emit) begin
        wr_en_q   <= 1'b1;
        wr_addr_q <= addr_q;
        wr_data_q <= acc_q;
        addr_q    <= addr_q + ADDR_W'(1);
      end
      if (row_end) begin
        row_vals_q <= '0;
        if (row_total != '0) begin
          rows_q <= rows_q + DIM_W'(1);
          if (!first_q) begin
            cols_q  <= row_total;
            first_q <= 1'b1;
          end else if (row_total != cols_q) begin
            shape_q <= 1'b1;
          end
        end
      end
      if (act && is_eof) begin
        fin_q  <= 1'b1;
        done_q <= 1'b1;
      end
    end
  end

  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign done      = done_q;
  assign mat_rows  = rows_q;
  assign mat_cols  = cols_q;
  assign shape_err = shape_q;
  assign ovf       = ovf_q;

  p_digit_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fin_q && in_byte >= 8'h30 && in_byte <= 8'h39) |=> !wr_en);

  p_cr_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte == 8'h0D) |=> (!wr_en && $stable(mat_rows) && $stable(mat_cols)));

  p_nl_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fin_q && have_q && !header_mode && in_byte == 8'h0A) |=> wr_en);

  p_shape_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shape_err |=> shape_err);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && $past(fin_q)) |-> (!wr_en && !done));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_hdr_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (header_mode && hdr_idx_q != 2'd2) |=> !wr_en);
endmodule

// File: tb/ascii_matrix_parser_bench.sv
`timescale 1ns/1ps
module ascii_matrix_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        header_mode = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_valid = 1'b0;
  logic        wr_en, done, shape_err, ovf;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  mat_rows, mat_cols;

  int total = 0;
  int bad = 0;
  int wcount = 0;
  int donecnt = 0;
  logic [15:0] got [256];

  always #2 clk = ~clk;

  ascii_matrix_parser u_ascii_matrix_parser (
    .clk(clk), .rst_n(rst_n), .header_mode(header_mode),
    .in_byte(in_byte), .in_valid(in_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .mat_rows(mat_rows), .mat_cols(mat_cols),
    .shape_err(shape_err), .ovf(ovf));

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      got[wr_addr] = wr_data;
      wcount++;
    end
    if (rst_n && done) donecnt++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit hm);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    header_mode = hm;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wcount = 0;
    donecnt = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_byte = b;
    in_valid = 1'b1;
  endtask

  task automatic send_num(input int v);
    int digs [6];
    int n = 0;
    int x = v;
    do begin
      digs[n] = x % 10;
      x = x / 10;
      n++;
    end while (x != 0);
    for (int i = n - 1; i >= 0; i--) send_byte(8'h30 + 8'(digs[i]));
  endtask

  task automatic send_eof();
    send_byte(8'h04);
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b1, "R8 done after eof", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  function automatic int val(int r, int c, int k, int nr, int nc);
    return ((r * 4 + c) * 4099 + k * 11 + nr * nc) % 65536;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit okv;
    do_reset(1'b0);
    chk(!wr_en && !done && !shape_err && !ovf, "R11 flags after reset", {wr_en, done, shape_err, ovf}, 0);
    chk(mat_rows == 0 && mat_cols == 0, "R11 dims after reset", {mat_rows, mat_cols}, 0);

    for (int k = 0; k < 3; k++)
      for (int nr = 1; nr <= 4; nr++)
        for (int nc = 1; nc <= 4; nc++) begin
          do_reset(1'b0);
          if (k == 2) begin send_byte(8'h20); send_byte(8'h0A); end
          for (int r = 0; r < nr; r++) begin
            for (int c = 0; c < nc; c++) begin
              send_num(val(r, c, k, nr, nc));
              if (c < nc - 1) begin
                if (k == 0) send_byte(8'h20);
                else if (k == 1) send_byte(8'h2C);
                else begin send_byte(8'h2C); send_byte(8'h20); send_byte(8'h20); end
              end
            end
            if (r < nr - 1 || k != 1) begin
              if (k == 2) send_byte(8'h0D);
              send_byte(8'h0A);
              if (k == 2) send_byte(8'h0A);
            end
          end
          send_eof();
          chk(wcount == nr * nc, "R2 write count", wcount, nr * nc);
          okv = 1;
          for (int i = 0; i < nr * nc; i++)
            if (got[i] != 16'(val(i / nc, i % nc, k, nr, nc))) okv = 0;
          chk(okv, "R1 R3 R4 values", okv, 1);
          chk(mat_rows == 8'(nr), "R6 rows", mat_rows, nr);
          chk(mat_cols == 8'(nc), "R5 cols", mat_cols, nc);
          chk(!shape_err && !ovf, "R7 R9 no flags", {shape_err, ovf}, 0);
        end

    send_byte(8'h35); send_byte(8'h20); send_byte(8'h36); send_byte(8'h0A); send_byte(8'h04);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk(wcount == 16, "R8 no writes after eof", wcount, 16);
    chk(donecnt == 1, "R8 single done", donecnt, 1);
    chk(mat_rows == 4 && mat_cols == 4, "R8 dims held", {mat_rows, mat_cols}, {8'd4, 8'd4});

    do_reset(1'b0);
    send_num(70000); send_byte(8'h20); send_num(12); send_eof();
    chk(got[0] == 16'hFFFF, "R9 saturated", got[0], 65535);
    chk(got[1] == 16'd12, "R9 next value", got[1], 12);
    chk(ovf == 1'b1, "R9 ovf set", ovf, 1);

    do_reset(1'b0);
    send_num(65535); send_eof();
    chk(got[0] == 16'hFFFF && ovf == 1'b0, "R9 max no ovf", ovf, 0);

    do_reset(1'b0);
    send_byte(8'h34); send_byte(8'h78); send_byte(8'h32); send_byte(8'h0D); send_byte(8'h20);
    send_num(9); send_eof();
    chk(wcount == 2 && got[0] == 16'd42, "R3 ignored byte", got[0], 42);

    do_reset(1'b0);
    send_num(1); send_byte(8'h20); send_num(2); send_byte(8'h20); send_num(3); send_byte(8'h0A);
    send_num(4); send_byte(8'h20); send_num(5); send_byte(8'h0A);
    send_eof();
    chk(shape_err == 1'b1, "R7 shape error", shape_err, 1);
    chk(mat_cols == 3 && mat_rows == 2, "R7 dims", {mat_rows, mat_cols}, {8'd2, 8'd3});

    do_reset(1'b1);
    send_num(2); send_byte(8'h0A); send_num(3); send_byte(8'h0A);
    for (int i = 0; i < 6; i++) begin
      send_num(100 + i * 7);
      send_byte((i % 3 == 2) ? 8'h0A : 8'h20);
    end
    send_eof();
    chk(mat_rows == 2 && mat_cols == 3, "R10 header dims", {mat_rows, mat_cols}, {8'd2, 8'd3});
    chk(wcount == 6, "R10 write count", wcount, 6);
    okv = 1;
    for (int i = 0; i < 6; i++) if (got[i] != 16'(100 + i * 7)) okv = 0;
    chk(okv, "R10 header values", okv, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule